// File: doc/BRIEF.md
# Debug Break Exception Arbiter

This block sits at the instruction-retire point of a processor's debug unit. For every instruction boundary it weighs the break conditions the comparators have flagged against the CPU exceptions raised for the same instruction. It then issues at most one outcome: a debug break, or the acceptance of one exception class. Independently of that outcome it decides whether the per-channel condition-match flags are raised.

Breaks that may not be taken where they match are parked in a per-channel pending register. This covers a pre-execution match on the delay slot of a return-from-exception, and any break satisfied while a hardware repeat loop runs. A parked break is released at a later boundary. Software reads the sticky match flags and clears them with a write strobe whose zero bits clear the matching flags. Comparators, exception vectoring and the register bus are outside the block.

Top module: `dbrk_arbiter`

## Requirements
- R1: At a boundary (`ret_valid_i`=1) with standby low, no delay-slot marker and no loop active, an enabled pre-execution match makes `brk_req_o` 1 in the next cycle and no exception is accepted, whatever exceptions are requested. The matching flag bits are set.
- R2: An enabled post-execution or data-access match on an instruction that also requests a re-execution exception (and no address error) gives `exc_acc_o`=1 with `exc_cls_o`=1, no break, and no flag set. The same match on a later boundary without the exception then breaks and sets the flag.
- R3: The same match together with a completion-type (trap) exception gives `exc_acc_o`=1 with `exc_cls_o`=2, no break, and the matching flag bits set.
- R4: The same match together with a data-access address error gives `exc_acc_o`=1 with `exc_cls_o`=3, no break, and the matching flag bits set.
- R5: An enabled post-execution or data-access match with no exception and no loop active breaks in the next cycle and sets the matching flag bits.
- R6: A pre-execution match on an instruction flagged `rte_dslot_i` gives no break and sets no flag at that boundary. The break is taken, and its flag set, at the next boundary.
- R7: While `standby_i` is 1 no break is requested and no flag is set by a match. Exceptions are still arbitrated as in R12.
- R8: A break satisfied while `loop_active_i` is 1 is held with no flag set. It is released, with its flag, at the first boundary at which `loop_active_i` is 0.
- R9: Match flags are sticky. A write strobe clears each flag whose write-data bit is 0 and keeps those written 1. A flag set in the same cycle as its clear ends up set.
- R10: A held break is discarded for every channel whose `brk_en_i` bit goes low, and on reset.
- R11: `brk_req_o` and `exc_acc_o` are never 1 in the same cycle.
- R12: Without a break taken, the accepted exception follows the priority address error (3) over re-execution (1) over trap (2). Class 0 means none. The outcome appears one cycle after the boundary.
- R13: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brk_en_i | input | NCH | Per-channel break enable |
| ret_valid_i | input | 1 | An instruction boundary is presented this cycle |
| pre_hit_i | input | NCH | Pre-execution match per channel |
| post_hit_i | input | NCH | Post-execution match per channel |
| dacc_hit_i | input | NCH | Data-access match per channel |
| exc_reexec_i | input | 1 | Re-execution-type exception requested |
| exc_trap_i | input | 1 | Completion-type exception requested |
| exc_addr_i | input | 1 | Data-access address error requested |
| rte_dslot_i | input | 1 | Instruction is the delay slot of a return-from-exception |
| standby_i | input | 1 | Debug module in standby |
| loop_active_i | input | 1 | Hardware repeat loop running |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | NCH | Flag write data (0 clears) |
| brk_req_o | output | 1 | Break taken (one-cycle pulse) |
| exc_acc_o | output | 1 | Exception accepted (one-cycle pulse) |
| exc_cls_o | output | 2 | Accepted class: 1 re-exec, 2 trap, 3 address error |
| match_flag_o | output | NCH | Sticky condition-match flags |

## Verification
The assertions assume that match and exception inputs carry meaning only when `ret_valid_i` is 1, and that an instruction re-executed after a re-execution exception presents its matches again. The stimulus drives every input at the falling edge and holds it for exactly one boundary. It returns to idle between cases, and it clears the flags and leaves no break held before each sweep point. So every combination of the three match kinds and three exception requests is presented against a known starting state.

// File: rtl/dbrk_pkg.sv
package dbrk_pkg;
  typedef enum logic [1:0] {
    EXC_NONE   = 2'd0,
    EXC_REEXEC = 2'd1,
    EXC_TRAP   = 2'd2,
    EXC_ADDR   = 2'd3
  } exc_cls_e;
endpackage

// File: rtl/dbrk_qual.sv
module dbrk_qual #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] en_i,
  input  logic [NCH-1:0] pre_i,
  input  logic [NCH-1:0] post_i,
  input  logic [NCH-1:0] dacc_i,
  output logic [NCH-1:0] pre_q_o,
  output logic [NCH-1:0] pst_q_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign pre_q_o[c] = en_i[c] & pre_i[c];
    assign pst_q_o[c] = en_i[c] & (post_i[c] | dacc_i[c]);
  end
endmodule

// File: rtl/dbrk_decide.sv
module dbrk_decide #(
  parameter int NCH = 4
) (
  input  logic                 ret_i,
  input  logic                 standby_i,
  input  logic                 dslot_i,
  input  logic                 loop_i,
  input  logic                 reexec_i,
  input  logic                 trap_i,
  input  logic                 addr_i,
  input  logic [NCH-1:0]       pre_q_i,
  input  logic [NCH-1:0]       pst_q_i,
  input  logic [NCH-1:0]       pend_i,
  output logic                 brk_o,
  output logic                 exc_o,
  output dbrk_pkg::exc_cls_e   cls_o,
  output logic [NCH-1:0]       set_o,
  output logic [NCH-1:0]       add_o,
  output logic                 rel_o
);
  import dbrk_pkg::*;

  logic           brk_ok;
  logic [NCH-1:0] pst_eff;

  assign brk_ok  = ret_i & ~standby_i;
  assign pst_eff = brk_ok ? pst_q_i : '0;

  always_comb begin
    brk_o = 1'b0;
    exc_o = 1'b0;
    cls_o = EXC_NONE;
    set_o = '0;
    add_o = '0;
    rel_o = 1'b0;
    if (ret_i) begin
      if (brk_ok && (|pend_i) && !loop_i) begin
        // held break acts ahead of the instruction itself
        brk_o = 1'b1;
        rel_o = 1'b1;
        set_o = pend_i | pre_q_i;
      end else if (brk_ok && (|pre_q_i) && !dslot_i && !loop_i) begin
        brk_o = 1'b1;
        set_o = pre_q_i;
      end else begin
        if (brk_ok && (|pre_q_i)) begin
          add_o = pre_q_i;
        end
        if (addr_i) begin
          exc_o = 1'b1;
          cls_o = EXC_ADDR;
          set_o = pst_eff;
        end else if (reexec_i) begin
          exc_o = 1'b1;
          cls_o = EXC_REEXEC;
        end else if (trap_i) begin
          exc_o = 1'b1;
          cls_o = EXC_TRAP;
          set_o = pst_eff;
        end else if (|pst_eff) begin
          if (loop_i) begin
            add_o = add_o | pst_eff;
          end else begin
            brk_o = 1'b1;
            set_o = pst_eff;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dbrk_pend.sv
module dbrk_pend #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] en_i,
  input  logic [NCH-1:0] add_i,
  input  logic           rel_i,
  output logic [NCH-1:0] pend_o
);
  logic [NCH-1:0] pend_q, pend_n;
  logic           pend_ld;

  always_comb begin
    pend_n  = (rel_i ? '0 : (pend_q | add_i)) & en_i;
    pend_ld = rel_i | (|add_i) | (|(pend_q & ~en_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_ld) pend_q <= pend_n;
  end

  assign pend_o = pend_q;

  // R10: a channel disabled in one cycle holds nothing in the next
  a_r10_discard: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(en_i)) == '0));
endmodule

// File: rtl/dbrk_flag.sv
module dbrk_flag #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_i,
  input  logic           wr_i,
  input  logic [NCH-1:0] wdata_i,
  output logic [NCH-1:0] flag_o
);
  logic [NCH-1:0] flag_q;

  for (genvar c = 0; c < NCH; c++) begin : g_bit
    logic clr, nxt, ld;
    always_comb begin
      clr = wr_i & ~wdata_i[c];
      nxt = set_i[c] | (flag_q[c] & ~clr);
      ld  = set_i[c] | clr;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flag_q[c] <= 1'b0;
      else if (ld) flag_q[c] <= nxt;
    end
  end

  assign flag_o = flag_q;

  // R9: a set event always lands, even against a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));
  // R9: flags hold when neither set nor written
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|set_i) && !wr_i) |=> (flag_q == $past(flag_q)));
endmodule

// File: rtl/dbrk_arbiter.sv
module dbrk_arbiter #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] brk_en_i,
  input  logic           ret_valid_i,
  input  logic [NCH-1:0] pre_hit_i,
  input  logic [NCH-1:0] post_hit_i,
  input  logic [NCH-1:0] dacc_hit_i,
  input  logic           exc_reexec_i,
  input  logic           exc_trap_i,
  input  logic           exc_addr_i,
  input  logic           rte_dslot_i,
  input  logic           standby_i,
  input  logic           loop_active_i,
  input  logic           flag_wr_i,
  input  logic [NCH-1:0] flag_wdata_i,
  output logic           brk_req_o,
  output logic           exc_acc_o,
  output logic [1:0]     exc_cls_o,
  output logic [NCH-1:0] match_flag_o
);
  import dbrk_pkg::*;

  logic [NCH-1:0] pre_q, pst_q, pend, set_m, add_m;
  logic           brk_n, exc_n, rel;
  exc_cls_e       cls_n;
  logic           brk_q, exc_q;
  logic [1:0]     cls_q;

  dbrk_qual #(.NCH(NCH)) u_qual (
    .en_i(brk_en_i), .pre_i(pre_hit_i), .post_i(post_hit_i),
    .dacc_i(dacc_hit_i), .pre_q_o(pre_q), .pst_q_o(pst_q)
  );

  dbrk_decide #(.NCH(NCH)) u_dec (
    .ret_i(ret_valid_i), .standby_i(standby_i), .dslot_i(rte_dslot_i),
    .loop_i(loop_active_i), .reexec_i(exc_reexec_i), .trap_i(exc_trap_i),
    .addr_i(exc_addr_i), .pre_q_i(pre_q), .pst_q_i(pst_q), .pend_i(pend),
    .brk_o(brk_n), .exc_o(exc_n), .cls_o(cls_n), .set_o(set_m),
    .add_o(add_m), .rel_o(rel)
  );

  dbrk_pend #(.NCH(NCH)) u_pend (
    .clk(clk), .rst_n(rst_n), .en_i(brk_en_i), .add_i(add_m),
    .rel_i(rel), .pend_o(pend)
  );

  dbrk_flag #(.NCH(NCH)) u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(set_m), .wr_i(flag_wr_i),
    .wdata_i(flag_wdata_i), .flag_o(match_flag_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q <= 1'b0;
      exc_q <= 1'b0;
      cls_q <= 2'd0;
    end else begin
      brk_q <= brk_n;
      exc_q <= exc_n;
      cls_q <= cls_n;
    end
  end

  assign brk_req_o = brk_q;
  assign exc_acc_o = exc_q;
  assign exc_cls_o = cls_q;

  // R11: one outcome per instruction
  a_r11_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(brk_req_o && exc_acc_o));

  // R7: standby suppresses breaks
  a_r7_standby: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> !brk_req_o);

  // R1: pre-execution break outranks all exceptions
  a_r1_pre_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid_i && !standby_i && !rte_dslot_i && !loop_active_i &&
     (|(pre_hit_i & brk_en_i)))
    |=> (brk_req_o && !exc_acc_o));

  // R2: re-execution exception wins and leaves flags untouched
  a_r2_reexec: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid_i && !standby_i && exc_reexec_i && !exc_addr_i &&
     ((pre_hit_i & brk_en_i) == '0) &&
     (|((post_hit_i | dacc_hit_i) & brk_en_i)) &&
     ((pend == '0) || loop_active_i))
    |=> (exc_acc_o && (exc_cls_o == 2'd1) && !brk_req_o &&
         ((match_flag_o & ~$past(match_flag_o)) == '0)));

  // R6: a delay-slot pre-execution match does not break there
  a_r6_dslot: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid_i && rte_dslot_i && (pend == '0) &&
     (((post_hit_i | dacc_hit_i) & brk_en_i) == '0))
    |=> !brk_req_o);
endmodule

// File: tb/sim_dbrk_arbiter.sv
`timescale 1ns/1ps
module sim_dbrk_arbiter;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] brk_en, pre, post, dacc, wdata, flag;
  logic           ret, reexec, trap, addr, dslot, stby, loop_a, wr;
  logic           brk, exc;
  logic [1:0]     cls;
  int             total = 0;
  int             bad = 0;

  always #10 clk = ~clk;

  dbrk_arbiter #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .brk_en_i(brk_en), .ret_valid_i(ret),
    .pre_hit_i(pre), .post_hit_i(post), .dacc_hit_i(dacc),
    .exc_reexec_i(reexec), .exc_trap_i(trap), .exc_addr_i(addr),
    .rte_dslot_i(dslot), .standby_i(stby), .loop_active_i(loop_a),
    .flag_wr_i(wr), .flag_wdata_i(wdata), .brk_req_o(brk),
    .exc_acc_o(exc), .exc_cls_o(cls), .match_flag_o(flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ret = 0; pre = '0; post = '0; dacc = '0; reexec = 0; trap = 0;
    addr = 0; dslot = 0; stby = 0; loop_a = 0; wr = 0; wdata = '0;
  endtask

  task automatic nx();
    @(negedge clk);
    idle();
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_flags();
    nx(); wr = 1; wdata = '0; cyc();
    nx(); cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; brk_en = '1; idle();
    repeat (3) @(posedge clk);
    #1;
    chk("R13 brk", brk, 0); chk("R13 exc", exc, 0);
    chk("R13 cls", cls, 0); chk("R13 flag", flag, 0);
    @(negedge clk); rst_n = 1;

    // sweep: pre on ch0, post on ch1, data access on ch2
    for (int v = 0; v < 64; v++) begin
      logic e_brk, e_exc;
      logic [1:0] e_cls;
      logic [NCH-1:0] e_flag, pm;
      string tag;
      pm = (v[1] ? 4'b0010 : 4'b0000) | (v[2] ? 4'b0100 : 4'b0000);
      e_brk = 0; e_exc = 0; e_cls = 0; e_flag = '0;
      if (v[0]) begin
        e_brk = 1; e_flag = 4'b0001; tag = "R1";
      end else if (pm != 0) begin
        if (v[5])      begin e_exc = 1; e_cls = 3; e_flag = pm; tag = "R4"; end
        else if (v[3]) begin e_exc = 1; e_cls = 1; tag = "R2"; end
        else if (v[4]) begin e_exc = 1; e_cls = 2; e_flag = pm; tag = "R3"; end
        else           begin e_brk = 1; e_flag = pm; tag = "R5"; end
      end else begin
        tag = "R12";
        if (v[5])      begin e_exc = 1; e_cls = 3; end
        else if (v[3]) begin e_exc = 1; e_cls = 1; end
        else if (v[4]) begin e_exc = 1; e_cls = 2; end
      end
      nx();
      ret = 1; pre = {3'b0, v[0]}; post = {2'b0, v[1], 1'b0};
      dacc = {1'b0, v[2], 2'b0}; reexec = v[3]; trap = v[4]; addr = v[5];
      cyc();
      chk({tag, " brk"}, brk, e_brk);
      chk({tag, " exc"}, exc, e_exc);
      chk({tag, " cls"}, cls, e_cls);
      chk({tag, " flag"}, flag, e_flag);
      chk("R11 excl", brk & exc, 0);
      clear_flags();
    end

    // R2: re-executed instruction without the exception now breaks
    nx(); ret = 1; post = 4'b0010; reexec = 1; cyc();
    chk("R2 first pass flag", flag, 0);
    nx(); ret = 1; post = 4'b0010; cyc();
    chk("R2 re-run brk", brk, 1); chk("R2 re-run flag", flag, 4'b0010);
    clear_flags();

    // R6: delay-slot deferral
    nx(); ret = 1; pre = 4'b0001; dslot = 1; cyc();
    chk("R6 slot brk", brk, 0); chk("R6 slot flag", flag, 0);
    nx(); ret = 1; cyc();
    chk("R6 target brk", brk, 1); chk("R6 target flag", flag, 4'b0001);
    clear_flags();

    // R8: loop hold and release
    nx(); ret = 1; loop_a = 1; post = 4'b0010; cyc();
    chk("R8 held brk", brk, 0); chk("R8 held flag", flag, 0);
    nx(); ret = 1; loop_a = 1; cyc();
    chk("R8 still held", brk, 0);
    nx(); loop_a = 0; cyc();
    chk("R8 no boundary", brk, 0);
    nx(); ret = 1; cyc();
    chk("R8 release brk", brk, 1); chk("R8 release flag", flag, 4'b0010);
    nx(); ret = 1; cyc();
    chk("R8 once only", brk, 0);
    clear_flags();

    // R7: standby
    nx(); ret = 1; stby = 1; pre = 4'b0001; post = 4'b0010; cyc();
    chk("R7 brk", brk, 0); chk("R7 flag", flag, 0);
    nx(); ret = 1; stby = 1; post = 4'b0010; trap = 1; cyc();
    chk("R7 exc", exc, 1); chk("R7 cls", cls, 2); chk("R7 flag trap", flag, 0);

    // R10: disable discards a held break
    nx(); ret = 1; loop_a = 1; pre = 4'b1000; cyc();
    nx(); brk_en = 4'b0111; cyc();
    nx(); brk_en = 4'b1111; cyc();
    nx(); ret = 1; cyc();
    chk("R10 disable brk", brk, 0); chk("R10 disable flag", flag, 0);
    // R10: reset discards a held break
    nx(); ret = 1; loop_a = 1; pre = 4'b0100; cyc();
    nx(); rst_n = 0; cyc();
    nx(); rst_n = 1; cyc();
    nx(); ret = 1; cyc();
    chk("R10 reset brk", brk, 0);

    // R9: write-zero clear, write-one keep, set beats clear
    nx(); ret = 1; post = 4'b0011; cyc();
    chk("R9 set", flag, 4'b0011);
    nx(); wr = 1; wdata = 4'b1111; cyc();
    chk("R9 write one keeps", flag, 4'b0011);
    nx(); wr = 1; wdata = 4'b1110; cyc();
    chk("R9 clear bit0", flag, 4'b0010);
    nx(); ret = 1; post = 4'b0100; wr = 1; wdata = 4'b0000; cyc();
    chk("R9 set wins", flag, 4'b0100);
    nx(); cyc();
    chk("R9 sticky", flag, 4'b0100);

    nx();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule